// File: doc/BRIEF.md
# Interrupt Acceptance and Processor Status Control

This block keeps the processor status word: a carry flag, a debug flag, zero and sign flags, a register-bank select flag, an overflow flag, a global interrupt-enable flag, a stack-pointer select flag and a 3-bit processor priority level. It decides on each cycle whether the pending maskable interrupt request is taken. A request is taken only when interrupts are enabled and the request priority is strictly above the current level. When a request is taken, the block raises a one-cycle accept pulse and, on the same clock edge, clears the enable flag and the stack-select flag.

The core feeds three other sources into the same word. A software interrupt instruction arrives with its number, and a number from 0 to 31 also selects the interrupt stack. The ALU supplies a result together with its carry and overflow, and the block derives the zero and sign flags from that result. A software write loads the whole word at once. Vector fetch, context saving and the register file belong to neighbouring blocks.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `status_word` is 0 and `irq_ack` is 0.
- R2: Field positions in `status_word`: carry bit 0, debug bit 1, zero bit 2, sign bit 3, bank bit 4, overflow bit 5, interrupt-enable bit 6, stack-select bit 7, level bits 14:12. Bits 11:8 and bit 15 are reserved. They are ignored on a write and always read 0. A write with no competing source loads the other eleven bits exactly.
- R3: A request sampled at a clock edge is taken only when `irq_req` is 1, the enable flag is 1, and `irq_pri` is strictly greater than the level field. A priority equal to the level is refused.
- R4: `irq_ack` is 1 for exactly the cycle after the edge at which the request was taken. It is never high for two cycles in a row, even when the request is held.
- R5: A taken request clears the enable flag and the stack-select flag on the edge that raises `irq_ack`. The level, bank, debug and ALU flags keep their values.
- R6: A software interrupt with `swi_num` at or below 31 clears the stack-select flag. A number above 31 leaves that flag unchanged. A software interrupt never changes the enable flag and never raises `irq_ack`.
- R7: An ALU update sets zero to 1 exactly when `alu_result` is 0, sets sign to the result's top bit, and copies `alu_carry` and `alu_ovf` into carry and overflow. No other field changes.
- R8: When sources collide in one cycle, a taken request or a low-numbered software interrupt overrides a software write for the flags it clears. An ALU update overrides a software write for carry, zero, sign and overflow.
- R9: The debug flag changes only through a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Maskable interrupt request pending |
| irq_pri | input | 3 | Priority of the pending request |
| swi_valid | input | 1 | Software interrupt instruction executes this cycle |
| swi_num | input | SWI_NUM_W (6) | Software interrupt number |
| alu_valid | input | 1 | ALU flag update this cycle |
| alu_result | input | DATA_W (16) | ALU result |
| alu_carry | input | 1 | ALU carry or borrow out |
| alu_ovf | input | 1 | ALU signed overflow |
| wr_en | input | 1 | Software write of the status word |
| wr_data | input | 16 | Status word to load |
| irq_ack | output | 1 | One-cycle accept pulse |
| status_word | output | 16 | Current status word |

## Verification
The bench uses the default parameters: a 16-bit ALU result, a 6-bit software interrupt number and a clear limit of 31. With a 6-bit number, values on both sides of the limit can be reached, so both branches of the stack-select rule are exercised, including 31 and 32. A 16-bit result lets random updates produce zero, negative and positive values. All eight request priorities can be played against all eight levels, so the equal-priority refusal and the level 7 case where nothing can be taken are both reachable.

// File: rtl/irqf_pkg.sv
// Package: field layout of the processor status word and helpers to move
// between the packed register view and the 16-bit software view.
// Assumes the level field is 3 bits and the word is 16 bits wide.
package irqf_pkg;
    localparam int WORD_W  = 16;
    localparam int LVL_W   = 3;
    localparam int POS_C   = 0;
    localparam int POS_D   = 1;
    localparam int POS_Z   = 2;
    localparam int POS_S   = 3;
    localparam int POS_B   = 4;
    localparam int POS_O   = 5;
    localparam int POS_I   = 6;
    localparam int POS_U   = 7;
    localparam int POS_LVL = 12;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             u;
        logic             i;
        logic             o;
        logic             b;
        logic             s;
        logic             z;
        logic             d;
        logic             c;
    } flags_t;

    // Place each flag at its bit position; reserved positions come out 0.
    function automatic logic [WORD_W-1:0] pack_word(input flags_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_C] = f.c;
        w[POS_D] = f.d;
        w[POS_Z] = f.z;
        w[POS_S] = f.s;
        w[POS_B] = f.b;
        w[POS_O] = f.o;
        w[POS_I] = f.i;
        w[POS_U] = f.u;
        w[POS_LVL +: LVL_W] = f.lvl;
        return w;
    endfunction

    // Pick the live fields out of a written word; reserved bits are dropped.
    function automatic flags_t unpack_word(input logic [WORD_W-1:0] w);
        flags_t f;
        f.c   = w[POS_C];
        f.d   = w[POS_D];
        f.z   = w[POS_Z];
        f.s   = w[POS_S];
        f.b   = w[POS_B];
        f.o   = w[POS_O];
        f.i   = w[POS_I];
        f.u   = w[POS_U];
        f.lvl = w[POS_LVL +: LVL_W];
        return f;
    endfunction

    localparam logic [WORD_W-1:0] LIVE_MASK = pack_word(flags_t'('1));
endpackage

// File: rtl/irqf_accept.sv
// Module: acceptance decision for a maskable request.
// Purely combinational; takes the request only when enabled and strictly
// above the current level. Assumes request and level share one width.
module irqf_accept #(
    parameter int PRI_W = 3
) (
    input  logic             req,
    input  logic [PRI_W-1:0] pri,
    input  logic             ie,
    input  logic [PRI_W-1:0] lvl,
    output logic             take
);
    // Strict comparison: an equal priority is refused.
    always_comb begin
        take = req && ie && (pri > lvl);
    end
endmodule

// File: rtl/irqf_alu_flags.sv
// Module: derives the arithmetic flags from an ALU result.
// Zero and sign come from the result itself; carry and overflow are passed
// through from the ALU. Assumes a two's complement result.
module irqf_alu_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic              z,
    output logic              s,
    output logic              c,
    output logic              o
);
    localparam int MSB = DATA_W - 1;

    // Flag derivation from the result word.
    always_comb begin
        z = ~|result;
        s = result[MSB];
        c = carry_in;
        o = ovf_in;
    end
endmodule

// File: rtl/irqf_swi_dec.sv
// Module: decides whether a software interrupt number selects the
// interrupt stack. Numbers up to CLR_LAST do; higher numbers do not.
// When every encodable number is in range the compare is removed.
module irqf_swi_dec #(
    parameter int NUM_W    = 6,
    parameter int CLR_LAST = 31
) (
    input  logic             valid,
    input  logic [NUM_W-1:0] num,
    output logic             clr_u
);
    localparam int NUM_MAX = (1 << NUM_W) - 1;

    generate
        if (CLR_LAST >= NUM_MAX) begin : g_all
            // Every number is low enough: any instruction clears the flag.
            always_comb clr_u = valid;
        end else begin : g_cmp
            // Range check against the last clearing number.
            always_comb clr_u = valid && (int'(num) <= CLR_LAST);
        end
    endgenerate
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: processor status word and interrupt acceptance.
// Holds the 11 live status bits, takes maskable requests, and merges
// software writes, ALU flag updates and software interrupt effects.
// Precedence: write < ALU flags < acceptance/software interrupt clears.
// Assumes synchronous active-low reset and one clock domain.
module irq_flag_ctrl
    import irqf_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SWI_NUM_W    = 6,
    parameter int SWI_CLR_LAST = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_req,
    input  logic [LVL_W-1:0]     irq_pri,
    input  logic                 swi_valid,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 alu_valid,
    input  logic [DATA_W-1:0]    alu_result,
    input  logic                 alu_carry,
    input  logic                 alu_ovf,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 irq_ack,
    output logic [WORD_W-1:0]    status_word
);
    flags_t cur_q;
    flags_t nxt;
    logic   take;
    logic   swi_clr;
    logic   a_z, a_s, a_c, a_o;

    irqf_accept #(.PRI_W(LVL_W)) u_accept (
        .req  (irq_req),
        .pri  (irq_pri),
        .ie   (cur_q.i),
        .lvl  (cur_q.lvl),
        .take (take)
    );

    irqf_alu_flags #(.DATA_W(DATA_W)) u_alu (
        .result   (alu_result),
        .carry_in (alu_carry),
        .ovf_in   (alu_ovf),
        .z        (a_z),
        .s        (a_s),
        .c        (a_c),
        .o        (a_o)
    );

    irqf_swi_dec #(.NUM_W(SWI_NUM_W), .CLR_LAST(SWI_CLR_LAST)) u_swi (
        .valid (swi_valid),
        .num   (swi_num),
        .clr_u (swi_clr)
    );

    // Next status word, layering the sources from lowest to highest precedence.
    always_comb begin
        nxt = cur_q;
        if (wr_en) begin
            nxt = unpack_word(wr_data);
        end
        if (alu_valid) begin
            nxt.z = a_z;
            nxt.s = a_s;
            nxt.c = a_c;
            nxt.o = a_o;
        end
        if (take) begin
            nxt.i = 1'b0;
            nxt.u = 1'b0;
        end
        if (swi_clr) begin
            nxt.u = 1'b0;
        end
    end

    // Status register and accept pulse, updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            irq_ack <= 1'b0;
        end else begin
            cur_q   <= nxt;
            irq_ack <= take;
        end
    end

    // Software view with reserved positions reading as 0.
    always_comb begin
        status_word = pack_word(cur_q);
    end
endmodule

// File: rtl/irqf_chk.sv
// Module: property checker for irq_flag_ctrl, attached by bind below.
// Observes only the top-level ports.
module irqf_chk
    import irqf_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SWI_NUM_W    = 6,
    parameter int SWI_CLR_LAST = 31
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_req,
    input logic [LVL_W-1:0]     irq_pri,
    input logic                 swi_valid,
    input logic [SWI_NUM_W-1:0] swi_num,
    input logic                 alu_valid,
    input logic [DATA_W-1:0]    alu_result,
    input logic                 alu_carry,
    input logic                 alu_ovf,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic                 irq_ack,
    input logic [WORD_W-1:0]    status_word
);
    logic             st_i, st_u, st_d, st_z, st_s, st_c, st_o;
    logic [LVL_W-1:0] st_lvl;
    logic             elig;
    logic             swi_low;

    // Field views of the observed status word.
    always_comb begin
        st_i    = status_word[POS_I];
        st_u    = status_word[POS_U];
        st_d    = status_word[POS_D];
        st_z    = status_word[POS_Z];
        st_s    = status_word[POS_S];
        st_c    = status_word[POS_C];
        st_o    = status_word[POS_O];
        st_lvl  = status_word[POS_LVL +: LVL_W];
        elig    = irq_req && st_i && (irq_pri > st_lvl);
        swi_low = swi_valid && (int'(swi_num) <= SWI_CLR_LAST);
    end

    // R3
    accept_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elig |=> irq_ack);

    // R3
    refuse_ineligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !elig |=> !irq_ack);

    // R4
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R5
    ack_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!st_i && !st_u));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~LIVE_MASK) == '0);

    // R2
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !alu_valid && !elig && !swi_valid)
        |=> status_word == ($past(wr_data) & LIVE_MASK));

    // R6
    swi_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swi_low |=> !st_u);

    // R6
    swi_high_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_valid && !swi_low && !wr_en && !elig) |=> $stable(st_u));

    // R7
    alu_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |=> (st_z == ($past(alu_result) == '0))
                   && (st_s == $past(alu_result[DATA_W-1]))
                   && (st_c == $past(alu_carry))
                   && (st_o == $past(alu_ovf)));

    // R9
    debug_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_d));
endmodule

bind irq_flag_ctrl irqf_chk #(
    .DATA_W       (DATA_W),
    .SWI_NUM_W    (SWI_NUM_W),
    .SWI_CLR_LAST (SWI_CLR_LAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_pri     (irq_pri),
    .swi_valid   (swi_valid),
    .swi_num     (swi_num),
    .alu_valid   (alu_valid),
    .alu_result  (alu_result),
    .alu_carry   (alu_carry),
    .alu_ovf     (alu_ovf),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .irq_ack     (irq_ack),
    .status_word (status_word)
);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
    localparam logic [15:0] LIVE = 16'h70FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_pri = '0;
    logic        swi_valid = 1'b0;
    logic [5:0]  swi_num = '0;
    logic        alu_valid = 1'b0;
    logic [15:0] alu_result = '0;
    logic        alu_carry = 1'b0;
    logic        alu_ovf = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_ack;
    logic [15:0] status_word;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_word = '0;

    irq_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pri(irq_pri),
        .swi_valid(swi_valid), .swi_num(swi_num), .alu_valid(alu_valid),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
        .status_word(status_word)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Acceptance rule from R3.
    function automatic logic model_take(input logic [15:0] w, input logic req, input logic [2:0] pri);
        return req && w[6] && (pri > w[14:12]);
    endfunction

    // Next word from R2, R5, R6, R7 and R8.
    function automatic logic [15:0] model_next(
        input logic [15:0] w, input logic take, input logic sv, input logic [5:0] sn,
        input logic av, input logic [15:0] ar, input logic ac, input logic ao,
        input logic we, input logic [15:0] wd);
        logic [15:0] n;
        n = w;
        if (we) n = wd & LIVE;
        if (av) begin
            n[0] = ac; n[2] = (ar == 16'h0); n[3] = ar[15]; n[5] = ao;
        end
        if (take) begin n[6] = 1'b0; n[7] = 1'b0; end
        if (sv && sn <= 6'd31) n[7] = 1'b0;
        return n;
    endfunction

    // Drive one cycle at a falling edge, check after the next rising edge.
    task automatic drive(input string tag, input logic req, input logic [2:0] pri,
                         input logic sv, input logic [5:0] sn, input logic av,
                         input logic [15:0] ar, input logic ac, input logic ao,
                         input logic we, input logic [15:0] wd);
        logic        e_ack;
        logic [15:0] e_word;
        irq_req = req; irq_pri = pri; swi_valid = sv; swi_num = sn;
        alu_valid = av; alu_result = ar; alu_carry = ac; alu_ovf = ao;
        wr_en = we; wr_data = wd;
        e_ack  = model_take(m_word, req, pri);
        e_word = model_next(m_word, e_ack, sv, sn, av, ar, ac, ao, we, wd);
        m_word = e_word;
        @(negedge clk);
        chk(tag, {15'h0, irq_ack}, {15'h0, e_ack});
        chk("R2", status_word & ~LIVE, 16'h0);
        chk("R2", status_word & 16'h7010, e_word & 16'h7010);
        chk("R5", status_word & 16'h00C0, e_word & 16'h00C0);
        chk("R7", status_word & 16'h002D, e_word & 16'h002D);
        chk("R9", status_word & 16'h0002, e_word & 16'h0002);
    endtask

    task automatic wr(input string tag, input logic [15:0] wd);
        drive(tag, 1'b0, 3'd0, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, wd);
    endtask

    task automatic idle(input string tag);
        drive(tag, 1'b0, 3'd0, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        // R1: word and pulse are zero while reset is held
        chk("R1", status_word, 16'h0);
        chk("R1", {15'h0, irq_ack}, 16'h0);
        rst_n = 1'b1;
        idle("R1");
        chk("R1", status_word, 16'h0);

        // R2: reserved bits ignored, live bits loaded
        wr("R2", 16'hFFFF);
        chk("R2", status_word, 16'h70FF);
        wr("R2", 16'h8F00);
        chk("R2", status_word, 16'h0000);

        // R3: equal priority refused, one above taken
        wr("R3", 16'h30C0);
        drive("R3", 1'b1, 3'd3, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        drive("R3", 1'b1, 3'd4, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R5", status_word, 16'h3000);
        // R3: enable clear blocks even the top priority
        wr("R3", 16'h0080);
        drive("R3", 1'b1, 3'd7, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        // R3: level 7 refuses everything
        wr("R3", 16'h70C0);
        drive("R3", 1'b1, 3'd7, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);

        // R4: held request gives one pulse
        wr("R4", 16'h00C5);
        for (int k = 0; k < 3; k++)
            drive("R4", 1'b1, 3'd1, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R5", status_word, 16'h0005);

        // R6: number 31 clears stack select, 32 keeps it
        wr("R6", 16'h00C0);
        drive("R6", 1'b0, 3'd0, 1'b1, 6'd32, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R6", status_word, 16'h00C0);
        drive("R6", 1'b0, 3'd0, 1'b1, 6'd31, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R6", status_word, 16'h0040);

        // R8: acceptance beats a write that sets enable and stack select
        wr("R8", 16'h00C0);
        drive("R8", 1'b1, 3'd2, 1'b0, 6'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 16'h00C0);
        chk("R8", status_word, 16'h0000);
        // R8: ALU beats a write for its flags
        drive("R8", 1'b0, 3'd0, 1'b0, 6'd0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h002A);
        chk("R8", status_word, 16'h0007);
        // R7: negative result with overflow
        drive("R7", 1'b0, 3'd0, 1'b0, 6'd0, 1'b1, 16'h8001, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R7", status_word, 16'h002A);

        // Random mix checked against the model
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ar;
            ar = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
            drive("R3", ($urandom % 2) == 1, 3'($urandom), ($urandom % 5) == 0,
                  6'($urandom), ($urandom % 3) == 0, ar, 1'($urandom), 1'($urandom),
                  ($urandom % 4) == 0, 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule